// File: doc/BRIEF.md
# Dual-Edge LCD Pixel Capture

This block listens, without driving anything, on a parallel 18-bit RGB display bus that carries pixels for two screens. The two screens share one pixel clock. The lower screen's pixel is valid at each rising edge and the upper screen's pixel at each falling edge. The bus has no horizontal sync, so line boundaries come from counting pixel clocks: every `LINE_CLKS` rising edges form one line. The vertical sync restarts both the pixel count and the line count.

The display clock, vertical sync and colour lines are brought into a faster system clock domain, at least four times the pixel rate, through two-flop synchronizers. Edges are found on the synchronized clock, and the colour is latched one system cycle after each detected edge. Each visible pixel of a selected screen is emitted as one tagged word carrying the screen, x, y and colour. A frame buffer or a serial uplink takes these words on a valid/ready stream.

Capture is one-shot. An arm pulse makes the block wait for the next vertical sync, stream exactly one frame and then raise a done flag. A sink that is not ready loses the word, and the block records the loss in a sticky flag.

Top module: `lcd_dual_capture`

## Requirements
- R1: The colour sampled after a rising pixel-clock edge is emitted with `out_scr_o` = 0 (lower screen).
- R2: The colour sampled after a falling pixel-clock edge is emitted with `out_scr_o` = 1 (upper screen), carrying the same x and y as the rising edge just before it.
- R3: After a vertical sync, the n-th rising edge (counting from 0) has x = n mod `LINE_CLKS` and y = n div `LINE_CLKS`.
- R4: Only positions with x < `VIS_PIX` produce words. The remaining positions of a line are blanking.
- R5: Only lines with y < `VIS_LINES` produce words. The first rising edge of line `VIS_LINES` ends the frame.
- R6: A rising vertical sync restarts the x and y counts, whatever line position the bus had reached.
- R7: `sel_i[0]` enables lower-screen words and `sel_i[1]` enables upper-screen words. Pixels of a screen whose bit is 0 are dropped.
- R8: A one-cycle `arm_i` pulse clears `done_o`. The block then waits for the next rising vertical sync and streams exactly one frame. `done_o` is set when the frame ends, or when another vertical sync arrives first, and it stays set until the next arm. No word is produced while the block is not armed and running.
- R9: Each word is a one-cycle `out_valid_o` pulse. If `out_ready_i` is low in that cycle, the word is lost and `overflow_o` is set. `overflow_o` stays set until the next `arm_i` pulse.
- R10: After reset, `out_valid_o`, `done_o` and `overflow_o` are low.
- R11: `out_scr_o`, `out_x_o`, `out_y_o` and `out_rgb_o` hold the word's screen, x, y and sampled colour in the same cycle as `out_valid_o`. `out_rgb_o` equals the `rgb_i` value present at the sampled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk_i | input | 1 | Display pixel clock (asynchronous) |
| vsync_i | input | 1 | Display vertical sync, active high |
| rgb_i | input | 3*COLOR_W | Display colour bus |
| sel_i | input | 2 | Screen enables: bit 0 lower, bit 1 upper |
| arm_i | input | 1 | One-cycle pulse that starts a one-frame capture |
| out_ready_i | input | 1 | Sink ready |
| out_valid_o | output | 1 | Word valid, one-cycle pulse |
| out_scr_o | output | 1 | Screen of the word: 0 lower, 1 upper |
| out_x_o | output | X_W | Pixel column |
| out_y_o | output | Y_W | Pixel line |
| out_rgb_o | output | 3*COLOR_W | Pixel colour |
| done_o | output | 1 | Sticky frame-complete flag |
| overflow_o | output | 1 | Sticky dropped-word flag |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the end of a frame and the arrival of a vertical sync. A vertical sync can arrive while a frame is still running, and the same event then has to close the capture and restart the counters. The bench provokes this by cutting a frame short after one line plus three pixels. It then judges that `done_o` rises, that only the words before the cut appear, and that later pixels produce nothing.

The second pair is a word drop and the sticky overflow flag. The bench pulls ready low across several emitted words. It expects each lost word still to appear with the correct fields, and `overflow_o` to be set afterwards and to stay set until the next arm clears it.

// File: rtl/lcd_cap_pkg.sv
package lcd_cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_WAIT = 2'd1,
    CAP_RUN  = 2'd2
  } cap_state_e;

  localparam logic SCR_LOWER = 1'b0;
  localparam logic SCR_UPPER = 1'b1;
endpackage

// File: rtl/lcd_cap_sync.sv
module lcd_cap_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lcd_cap_edge.sv
module lcd_cap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_s_i,
  output logic rise_o,
  output logic fall_o
);
  logic pclk_q;

  // pulses land one cycle after detection: the data latch cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      pclk_q <= pclk_s_i;
      rise_o <= pclk_s_i & ~pclk_q;
      fall_o <= ~pclk_s_i & pclk_q;
    end
  end
endmodule

// File: rtl/lcd_cap_timing.sv
module lcd_cap_timing #(
  parameter int LINE_CLKS = 263,
  parameter int VIS_LINES = 192,
  parameter int XC_W      = $clog2(LINE_CLKS),
  parameter int YC_W      = $clog2(VIS_LINES + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            vs_i,
  output logic [XC_W-1:0] x_o,
  output logic [YC_W-1:0] y_o,
  output logic            pos_ok_o
);
  logic [XC_W-1:0] x_q, x_nxt;
  logic [YC_W-1:0] y_q, y_nxt;
  logic            fresh_q;

  always_comb begin
    if (fresh_q) begin
      x_nxt = '0;
      y_nxt = '0;
    end else if (x_q == XC_W'(LINE_CLKS - 1)) begin
      x_nxt = '0;
      y_nxt = (y_q == YC_W'(VIS_LINES)) ? y_q : y_q + 1'b1;
    end else begin
      x_nxt = x_q + 1'b1;
      y_nxt = y_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      y_q     <= '0;
      fresh_q <= 1'b1;
    end else if (vs_i) begin
      fresh_q <= 1'b1;
    end else if (rise_i) begin
      fresh_q <= 1'b0;
      x_q     <= x_nxt;
      y_q     <= y_nxt;
    end
  end

  // rising edge sees its own new position; falling edge reuses it
  assign x_o      = rise_i ? x_nxt : x_q;
  assign y_o      = rise_i ? y_nxt : y_q;
  assign pos_ok_o = !vs_i && (rise_i || !fresh_q);

  assert_line_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !vs_i && !fresh_q && x_q == XC_W'(LINE_CLKS - 1)) |=> (x_q == '0));

  assert_vsync_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_i && !rise_i) |=> (!pos_ok_o || (x_o == '0 && y_o == '0)));

  assert_line_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(y_q) <= VIS_LINES);
endmodule

// File: rtl/lcd_dual_capture.sv
module lcd_dual_capture
  import lcd_cap_pkg::*;
#(
  parameter int COLOR_W   = 6,
  parameter int LINE_CLKS = 263,
  parameter int VIS_PIX   = 256,
  parameter int VIS_LINES = 192,
  parameter int X_W       = 8,
  parameter int Y_W       = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pclk_i,
  input  logic                 vsync_i,
  input  logic [3*COLOR_W-1:0] rgb_i,
  input  logic [1:0]           sel_i,
  input  logic                 arm_i,
  input  logic                 out_ready_i,
  output logic                 out_valid_o,
  output logic                 out_scr_o,
  output logic [X_W-1:0]       out_x_o,
  output logic [Y_W-1:0]       out_y_o,
  output logic [3*COLOR_W-1:0] out_rgb_o,
  output logic                 done_o,
  output logic                 overflow_o
);
  localparam int RGB_W = 3 * COLOR_W;
  localparam int XC_W  = $clog2(LINE_CLKS);
  localparam int YC_W  = $clog2(VIS_LINES + 1);

  logic             pclk_s, vs_s, vs_q, vs_rise;
  logic [RGB_W-1:0] rgb_s;
  logic             rise_p, fall_p;
  logic [XC_W-1:0]  pix_x;
  logic [YC_W-1:0]  pix_y;
  logic             pos_ok, in_view, sel_ok, frame_end, emit;
  cap_state_e       state_q;

  lcd_cap_sync #(.W(RGB_W + 2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pclk_i, vsync_i, rgb_i}),
    .q_o   ({pclk_s, vs_s, rgb_s})
  );

  lcd_cap_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pclk_s_i(pclk_s),
    .rise_o  (rise_p),
    .fall_o  (fall_p)
  );

  lcd_cap_timing #(
    .LINE_CLKS(LINE_CLKS),
    .VIS_LINES(VIS_LINES),
    .XC_W     (XC_W),
    .YC_W     (YC_W)
  ) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise_p),
    .vs_i    (vs_s),
    .x_o     (pix_x),
    .y_o     (pix_y),
    .pos_ok_o(pos_ok)
  );

  assign vs_rise   = vs_s & ~vs_q;
  assign in_view   = (int'(pix_x) < VIS_PIX) && (int'(pix_y) < VIS_LINES);
  assign sel_ok    = rise_p ? sel_i[0] : sel_i[1];
  assign frame_end = (state_q == CAP_RUN) && rise_p && pos_ok && (int'(pix_y) >= VIS_LINES);
  assign emit      = (state_q == CAP_RUN) && (rise_p || fall_p) && pos_ok && in_view && sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q       <= 1'b0;
      state_q    <= CAP_IDLE;
      done_o     <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      vs_q <= vs_s;
      if (arm_i) begin
        state_q    <= CAP_WAIT;
        done_o     <= 1'b0;
        overflow_o <= 1'b0;
      end else begin
        if (out_valid_o && !out_ready_i) overflow_o <= 1'b1;
        case (state_q)
          CAP_WAIT: if (vs_rise) state_q <= CAP_RUN;
          CAP_RUN: begin
            if (vs_rise || frame_end) begin
              state_q <= CAP_IDLE;
              done_o  <= 1'b1;
            end
          end
          default: state_q <= CAP_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_scr_o   <= SCR_LOWER;
      out_x_o     <= '0;
      out_y_o     <= '0;
      out_rgb_o   <= '0;
    end else begin
      out_valid_o <= emit;
      if (emit) begin
        out_scr_o <= fall_p ? SCR_UPPER : SCR_LOWER;
        out_x_o   <= X_W'(pix_x);
        out_y_o   <= Y_W'(pix_y);
        out_rgb_o <= rgb_s;
      end
    end
  end

  assert_word_in_view_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(out_x_o) < VIS_PIX));

  assert_line_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(out_y_o) < VIS_LINES));

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_drop_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !arm_i) |=> overflow_o);

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !arm_i) |=> overflow_o);

  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o);

  assert_arm_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!done_o && !overflow_o));
endmodule

// File: tb/lcd_dual_capture_tb.sv
module lcd_dual_capture_tb_top;
  localparam int L  = 12;
  localparam int VP = 8;
  localparam int VL = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pclk = 1'b0, vsync = 1'b0, arm = 1'b0, rdy = 1'b1;
  logic [17:0] rgb = '0;
  logic [1:0]  sel = 2'b11;
  logic        out_valid, out_scr, done, ovf;
  logic [7:0]  out_x, out_y;
  logic [17:0] out_rgb;

  always #2 clk = ~clk;

  lcd_dual_capture #(
    .COLOR_W(6), .LINE_CLKS(L), .VIS_PIX(VP), .VIS_LINES(VL), .X_W(8), .Y_W(8)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pclk_i(pclk), .vsync_i(vsync), .rgb_i(rgb),
    .sel_i(sel), .arm_i(arm), .out_ready_i(rdy), .out_valid_o(out_valid),
    .out_scr_o(out_scr), .out_x_o(out_x), .out_y_o(out_y), .out_rgb_o(out_rgb),
    .done_o(done), .overflow_o(ovf)
  );

  typedef struct {
    logic        scr;
    int          x;
    int          y;
    logic [17:0] rgb;
  } exp_t;

  exp_t q[$];
  int   errs = 0, checks = 0, words = 0, k = 0, seed = 1;
  bit   m_run = 0, m_armed = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare every emitted word against the model queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      words++;
      if (q.size() == 0) begin
        chk(1'b0, "R8", "unexpected word", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_scr == e.scr, e.scr ? "R2" : "R1", "screen", int'(out_scr), int'(e.scr));
        chk(int'(out_x) == e.x, "R3 R6", "x", int'(out_x), e.x);
        chk(int'(out_y) == e.y, "R3 R6", "y", int'(out_y), e.y);
        chk(out_rgb == e.rgb, "R11", "rgb", int'(out_rgb), int'(e.rgb));
      end
    end
  end

  task automatic vs_pulse();
    @(negedge clk);
    vsync = 1'b1;
    if (m_run) m_run = 0;
    else if (m_armed) begin m_run = 1; m_armed = 0; end
    k = 0;
    repeat (8) @(negedge clk);
    vsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pix();
    int x, y;
    logic [17:0] lo, up;
    exp_t e;
    x = k % L;
    y = k / L;
    seed = (seed * 1103 + 12345) % 262139;
    lo = 18'(seed);
    up = 18'(seed * 7 + 99) ^ 18'h2AAAA;
    if (m_run) begin
      if (y >= VL) m_run = 0;
      else if (x < VP) begin
        if (sel[0]) begin e.scr = 1'b0; e.x = x; e.y = y; e.rgb = lo; q.push_back(e); end
        if (sel[1]) begin e.scr = 1'b1; e.x = x; e.y = y; e.rgb = up; q.push_back(e); end
      end
    end
    k++;
    rgb = lo;
    repeat (2) @(negedge clk);
    pclk = 1'b1;
    repeat (2) @(negedge clk);
    rgb = up;
    repeat (2) @(negedge clk);
    pclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic arm_pulse();
    @(negedge clk);
    arm = 1'b1;
    m_armed = 1;
    m_run = 0;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int w0;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
    chk(ovf == 1'b0, "R10", "overflow after reset", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // not armed: bus activity produces nothing
    vs_pulse();
    repeat (2 * L) pix();
    settle();
    chk(words == 0, "R8", "words while unarmed", words, 0);

    // full frame, both screens; a few stale pixels before the arming sync
    repeat (5) pix();
    arm_pulse();
    chk(done == 1'b0, "R8", "done cleared by arm", int'(done), 0);
    sel = 2'b11;
    vs_pulse();
    repeat (L * (VL + 2)) pix();
    settle();
    chk(done == 1'b1, "R8", "done after frame", int'(done), 1);
    chk(ovf == 1'b0, "R9", "no overflow with ready high", int'(ovf), 0);
    chk(words == 2 * VP * VL, "R4 R5", "word count both screens", words, 2 * VP * VL);
    chk(q.size() == 0, "R5", "pending words", q.size(), 0);

    // next sync without a new arm: only one frame per arm
    w0 = words;
    vs_pulse();
    repeat (L) pix();
    settle();
    chk(words == w0, "R8", "words after frame without arm", words - w0, 0);

    // lower only, with drops
    repeat (3) pix();
    arm_pulse();
    sel = 2'b01;
    w0 = words;
    vs_pulse();
    repeat (L) pix();
    rdy = 1'b0;
    repeat (3) pix();
    rdy = 1'b1;
    repeat (L * VL - 3) pix();
    settle();
    chk(ovf == 1'b1, "R9", "overflow after drop", int'(ovf), 1);
    chk(done == 1'b1, "R8", "done lower frame", int'(done), 1);
    chk(words - w0 == VP * VL, "R7", "lower-only count", words - w0, VP * VL);
    repeat (L) pix();
    settle();
    chk(ovf == 1'b1, "R9", "overflow sticky", int'(ovf), 1);

    // upper only, frame cut short by an early sync
    arm_pulse();
    chk(ovf == 1'b0, "R9", "overflow cleared by arm", int'(ovf), 0);
    sel = 2'b10;
    w0 = words;
    vs_pulse();
    repeat (L + 3) pix();
    settle();
    chk(done == 1'b0, "R8", "done before early sync", int'(done), 0);
    vs_pulse();
    repeat (L) pix();
    settle();
    chk(done == 1'b1, "R6", "done on early sync", int'(done), 1);
    chk(words - w0 == VP + 3, "R7", "upper-only count", words - w0, VP + 3);
    chk(q.size() == 0, "R6", "pending words", q.size(), 0);

    // no screen selected
    arm_pulse();
    sel = 2'b00;
    w0 = words;
    vs_pulse();
    repeat (L * (VL + 1)) pix();
    settle();
    chk(words == w0, "R7", "no-screen count", words - w0, 0);
    chk(done == 1'b1, "R8", "done no-screen frame", int'(done), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule